// File: doc/BRIEF.md
# Event Performance Monitor

This block counts processor activity for profiling. It has three 32-bit counters. The cycle counter runs on the clock. Each of the two event counters counts one event line, picked from a vector of single-cycle event pulses by an 8-bit code. Software reaches the block through a flat register port: a register select, a write enable, write data and combinational read data. The port gives access to one control word and to the three counter values.

The counters have no individual run bits. A single global enable gates all three. Software parks an event counter by giving it a code that never fires. When a counter wraps, it raises a sticky overflow flag inside the control word. A flag is cleared by writing a 1 to it, so a read-modify-write of the control word clears exactly the flags that the read returned. One interrupt line combines every flag with its own enable.

Top module: `perfmon_unit`

## Requirements
- R1: Register select 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write lands on the next clock edge, and read data follows the select with no delay.
- R2: The control word holds: global enable at bit 0; event-counter reset at bit 1; cycle-counter reset at bit 2; cycle divider at bit 3; interrupt enables at bits 4, 5 and 6 (event 0, event 1, cycle); overflow flags at bits 8, 9 and 10 (event 0, event 1, cycle); the event 1 code at bits 19:12; and the event 0 code at bits 27:20. All other bits read as 0. After reset the word reads 0x02020000: both codes are 0x20 and everything else is 0. All counters read 0.
- R3: While bit 0 is set and bit 3 is clear, the cycle counter increases by one on every clock edge. While bit 0 is clear, no counter changes except through a software write or a reset bit.
- R4: With bit 3 set, the cycle counter increases once every 64 enabled cycles. After a cycle-counter reset, the first increase comes on the 64th enabled edge.
- R5: An event counter increases on an enabled edge when its selected line is high. A code below the number of event lines selects that line. Code 0xFF counts every enabled cycle. Code 0x20, and every other code with no line behind it, never counts.
- R6: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag on the same edge. The flag stays set until software clears it.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 leaves it alone. Writing back a word just read clears only the flags that were set in it. If a wrap and a clear of the same flag land on one edge, the flag stays set.
- R8: Bit 1 clears both event counters, and bit 2 clears the cycle counter and its divider phase. The clear happens on the edge after the control write, the other counters are left unchanged, and both reset bits always read as 0.
- R9: The interrupt output is high exactly when some overflow flag is set together with its interrupt enable.
- R10: A software write to a counter takes priority over an increment or a pending reset of that counter on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| eventsIn | input | NUM_EVENTS | Single-cycle event pulses, one line per event code |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as the wrap that sets the flag. The bench loads event counter 1 with 0xFFFFFFFD and gives it the every-cycle code. It counts the edges after the enabling write and times a clear write to fall on the third edge, which is the wrap edge. The divider phase is also hard to observe, so the bench first clears it with the cycle reset bit. It then samples the counter on the 63rd and 64th enabled edges.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int SEL_W = 8;
  localparam int NUM_EVT_CTR = 2;
  localparam logic [SEL_W-1:0] CODE_STOP = 8'h20;
  localparam logic [SEL_W-1:0] CODE_ALWAYS = 8'hFF;
  // control word bit positions (decoded by software)
  localparam int B_EN = 0;
  localparam int B_EVT_RST = 1;
  localparam int B_CYC_RST = 2;
  localparam int B_DIV = 3;
  localparam int B_IEN = 4;   // 4 + counter slot
  localparam int B_OVF = 8;   // 8 + counter slot
  localparam int B_SEL1 = 12;
  localparam int B_SEL0 = 20;

  // strobes from the control half to the counter half
  typedef struct packed {
    logic countEn;
    logic divEn;
    logic cycClr;
    logic evtClr;
    logic cycWr;
    logic [NUM_EVT_CTR-1:0] evtWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] regSel,
  input  logic regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic cycWrap,
  input  logic [NUM_EVT_CTR-1:0] evtWrap,
  output ctrlStrobes_t strobes,
  output logic [NUM_EVT_CTR-1:0][SEL_W-1:0] evtSel,
  output logic [DATA_W-1:0] ctrlWord,
  output logic irq
);
  localparam int NSLOT = NUM_EVT_CTR + 1; // slot NUM_EVT_CTR is the cycle counter

  logic enReg, divReg, evtRstPend, cycRstPend;
  logic [NSLOT-1:0] ienReg, ovfReg, wrapVec;
  logic ctrlWr;

  assign ctrlWr = regWrEn && (regSel == 2'd0);
  assign wrapVec = {cycWrap, evtWrap};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0;
      divReg <= 1'b0;
      ienReg <= '0;
      evtSel[0] <= CODE_STOP;
      evtSel[1] <= CODE_STOP;
      evtRstPend <= 1'b0;
      cycRstPend <= 1'b0;
    end else begin
      evtRstPend <= ctrlWr && regWrData[B_EVT_RST];
      cycRstPend <= ctrlWr && regWrData[B_CYC_RST];
      if (ctrlWr) begin
        enReg <= regWrData[B_EN];
        divReg <= regWrData[B_DIV];
        ienReg <= regWrData[B_IEN +: NSLOT];
        evtSel[0] <= regWrData[B_SEL0 +: SEL_W];
        evtSel[1] <= regWrData[B_SEL1 +: SEL_W];
      end
    end
  end

  // sticky flags: a wrap wins over a same-edge clear
  for (genvar i = 0; i < NSLOT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ovfReg[i] <= 1'b0;
      else ovfReg[i] <= wrapVec[i] | (ovfReg[i] & ~(ctrlWr & regWrData[B_OVF + i]));
    end
  end

  assign irq = |(ovfReg & ienReg);

  always_comb begin
    ctrlWord = '0;
    ctrlWord[B_EN] = enReg;
    ctrlWord[B_DIV] = divReg;
    ctrlWord[B_IEN +: NSLOT] = ienReg;
    ctrlWord[B_OVF +: NSLOT] = ovfReg;
    ctrlWord[B_SEL1 +: SEL_W] = evtSel[1];
    ctrlWord[B_SEL0 +: SEL_W] = evtSel[0];
  end

  always_comb begin
    strobes.countEn = enReg;
    strobes.divEn = divReg;
    strobes.cycClr = cycRstPend;
    strobes.evtClr = evtRstPend;
    strobes.cycWr = regWrEn && (regSel == 2'd1);
    for (int i = 0; i < NUM_EVT_CTR; i++)
      strobes.evtWr[i] = regWrEn && (regSel == 2'(i + 2));
  end
endmodule

// File: rtl/perfmon_datapath.sv
module perfmon_datapath
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NUM_EVENTS = 24,
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic [CNT_W-1:0] wrData,
  input  logic [NUM_EVT_CTR-1:0][SEL_W-1:0] evtSel,
  input  logic [NUM_EVENTS-1:0] eventsIn,
  output logic [CNT_W-1:0] cycCnt,
  output logic [NUM_EVT_CTR-1:0][CNT_W-1:0] evtCnt,
  output logic cycWrap,
  output logic [NUM_EVT_CTR-1:0] evtWrap
);
  logic [DIV_LOG2-1:0] prescale;
  logic cycTick, cycInc;

  assign cycTick = strobes.countEn && (!strobes.divEn || (&prescale));
  assign cycInc = cycTick && !strobes.cycWr && !strobes.cycClr;
  assign cycWrap = cycInc && (&cycCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescale <= '0;
    else if (strobes.cycClr) prescale <= '0;
    else if (strobes.countEn) prescale <= prescale + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycCnt <= '0;
    else if (strobes.cycWr) cycCnt <= wrData;
    else if (strobes.cycClr) cycCnt <= '0;
    else if (cycTick) cycCnt <= cycCnt + 1'b1;
  end

  for (genvar c = 0; c < NUM_EVT_CTR; c++) begin : g_evt
    logic hit, inc;
    always_comb begin
      hit = 1'b0;
      for (int j = 0; j < NUM_EVENTS; j++)
        if (evtSel[c] == SEL_W'(j)) hit = eventsIn[j];
      if (evtSel[c] == CODE_ALWAYS) hit = 1'b1;
      if (evtSel[c] == CODE_STOP) hit = 1'b0;
    end
    assign inc = strobes.countEn && hit && !strobes.evtWr[c] && !strobes.evtClr;
    assign evtWrap[c] = inc && (&evtCnt[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtCnt[c] <= '0;
      else if (strobes.evtWr[c]) evtCnt[c] <= wrData;
      else if (strobes.evtClr) evtCnt[c] <= '0;
      else if (inc) evtCnt[c] <= evtCnt[c] + 1'b1;
    end
  end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter int NUM_EVENTS = 24,
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] regSel,
  input  logic regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_EVENTS-1:0] eventsIn,
  output logic irq
);
  ctrlStrobes_t strobes;
  logic [NUM_EVT_CTR-1:0][SEL_W-1:0] evtSel;
  logic [DATA_W-1:0] ctrlWord;
  logic [CNT_W-1:0] cycCnt;
  logic [NUM_EVT_CTR-1:0][CNT_W-1:0] evtCnt;
  logic cycWrap;
  logic [NUM_EVT_CTR-1:0] evtWrap;

  perfmon_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .cycWrap(cycWrap), .evtWrap(evtWrap),
    .strobes(strobes), .evtSel(evtSel), .ctrlWord(ctrlWord), .irq(irq)
  );

  perfmon_datapath #(.CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS), .DIV_LOG2(DIV_LOG2)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData[CNT_W-1:0]),
    .evtSel(evtSel), .eventsIn(eventsIn), .cycCnt(cycCnt), .evtCnt(evtCnt),
    .cycWrap(cycWrap), .evtWrap(evtWrap)
  );

  always_comb begin
    regRdData = '0;
    case (regSel)
      2'd0: regRdData = ctrlWord;
      2'd1: regRdData[CNT_W-1:0] = cycCnt;
      2'd2: regRdData[CNT_W-1:0] = evtCnt[0];
      default: regRdData[CNT_W-1:0] = evtCnt[1];
    endcase
  end
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker (
  input logic clk,
  input logic rstN,
  input logic [1:0] regSel,
  input logic regWrEn,
  input logic [31:0] regWrData,
  input logic irq,
  input logic [31:0] ctrlWord,
  input logic [31:0] cycCnt,
  input logic [31:0] evtCnt0,
  input logic [31:0] evtCnt1
);
  // R3: undivided cycle counting advances by one per edge
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[0] && !ctrlWord[3] && !regWrEn && !$past(regWrEn))
      |=> cycCnt == $past(cycCnt) + 32'd1);

  // R5: the stop code freezes event counter 0
  a_r5_stop_code: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[27:20] == 8'h20 && !regWrEn && !$past(regWrEn)) |=> $stable(evtCnt0));

  // R6: a flag survives any cycle without a clearing write
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[8] && !(regWrEn && regSel == 2'd0 && regWrData[8])) |=> ctrlWord[8]);

  // R8: event reset clears both event counters one edge after the write
  a_r8_evt_reset: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd0 && regWrData[1]) ##1 !(regWrEn && regSel[1])
      |=> (evtCnt0 == 32'd0 && evtCnt1 == 32'd0));

  // R9: interrupt tracks flags gated by enables
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(ctrlWord[10:8] & ctrlWord[6:4]));

  // R10: software write wins over counting
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd2) |=> evtCnt0 == $past(regWrData));
endmodule

bind perfmon_unit perfmon_checker chk_i (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
  .regWrData(regWrData), .irq(irq), .ctrlWord(ctrlWord),
  .cycCnt(cycCnt), .evtCnt0(evtCnt[0]), .evtCnt1(evtCnt[1])
);

// File: tb/perfmon_unit_tb_top.sv
module perfmon_unit_tb_top;
  localparam int NEV = 24;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NEV-1:0] eventsIn = '0;
  logic irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk; // 250 MHz

  perfmon_unit #(.NUM_EVENTS(NEV)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .eventsIn(eventsIn), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ctl(input logic en, input logic div, input logic [2:0] ien,
                                      input logic [7:0] s0, input logic [7:0] s1,
                                      input logic rstE, input logic rstC, input logic [2:0] clr);
    logic [31:0] w = '0;
    w[0] = en; w[1] = rstE; w[2] = rstC; w[3] = div;
    w[6:4] = ien; w[10:8] = clr; w[19:12] = s1; w[27:20] = s0;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regSel = sel; regWrEn = 1'b1; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdData;
  endtask

  task automatic parkAll();
    wrReg(0, ctl(0, 0, 3'b000, 8'h20, 8'h20, 0, 0, 3'b111));
  endtask

  task automatic tResetState();
    logic [31:0] v;
    rdReg(0, v); check("R2 reset control", v, 32'h0202_0000);
    rdReg(1, v); check("R2 reset cycle", v, 0);
    rdReg(3, v); check("R2 reset event1", v, 0);
    check("R9 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic tCycle();
    logic [31:0] v;
    parkAll();
    wrReg(1, 32'd100);
    wrReg(0, ctl(1, 0, 3'b000, 8'h20, 8'h20, 0, 0, 3'b000));
    repeat (10) @(negedge clk);
    rdReg(1, v); check("R3 cycle count", v, 32'd110);
    parkAll();
    rdReg(1, v);
    repeat (5) @(negedge clk);
    begin logic [31:0] w; rdReg(1, w); check("R3 disabled hold", w, v); end
  endtask

  task automatic tDivider();
    logic [31:0] v;
    wrReg(0, ctl(0, 0, 3'b000, 8'h20, 8'h20, 0, 1, 3'b000));
    @(negedge clk);
    rdReg(1, v); check("R8 cycle reset", v, 0);
    wrReg(0, ctl(1, 1, 3'b000, 8'h20, 8'h20, 0, 0, 3'b000));
    repeat (63) @(negedge clk);
    rdReg(1, v); check("R4 divider 63", v, 0);
    @(negedge clk);
    rdReg(1, v); check("R4 divider 64", v, 1);
    parkAll();
  endtask

  task automatic tEvents();
    logic [31:0] v;
    wrReg(2, 0); wrReg(3, 0);
    wrReg(0, ctl(1, 0, 3'b000, 8'd3, 8'd7, 0, 0, 3'b000));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      eventsIn = '0;
      eventsIn[3] = (i % 2 == 0);
      eventsIn[7] = (i >= 2);
      eventsIn[5] = 1'b1;
    end
    @(negedge clk);
    eventsIn = '0;
    rdReg(2, v); check("R5 event0 code3", v, 3);
    rdReg(3, v); check("R5 event1 code7", v, 4);
    parkAll();
  endtask

  task automatic tStop();
    logic [31:0] v;
    wrReg(2, 32'd50); wrReg(3, 32'd60);
    wrReg(0, ctl(1, 0, 3'b000, 8'h20, 8'h40, 0, 0, 3'b000));
    eventsIn = '1;
    repeat (6) @(negedge clk);
    rdReg(2, v); check("R5 stop code", v, 50);
    rdReg(3, v); check("R5 unused code", v, 60);
    wrReg(0, ctl(0, 0, 3'b000, 8'hFF, 8'd0, 0, 0, 3'b000));
    repeat (4) @(negedge clk);
    eventsIn = '0;
    rdReg(2, v); check("R3 disabled event", v, 50);
  endtask

  task automatic tOverflow();
    logic [31:0] v, c;
    parkAll();
    wrReg(3, 32'hFFFF_FFFE);
    c = ctl(1, 0, 3'b010, 8'h20, 8'hFF, 0, 0, 3'b000);
    wrReg(0, c);
    @(negedge clk);
    check("R6 no early irq", {31'd0, irq}, 0);
    @(negedge clk);
    rdReg(3, v); check("R6 wrap value", v, 0);
    rdReg(0, v); check("R6 flag set", {31'd0, v[9]}, 1);
    check("R9 irq high", {31'd0, irq}, 1);
    wrReg(0, c);
    rdReg(0, v); check("R7 zero keeps flag", {31'd0, v[9]}, 1);
    rdReg(0, v);
    wrReg(0, v);
    rdReg(0, c); check("R7 writeback clears", c, v & ~32'h0000_0700);
    check("R9 irq low", {31'd0, irq}, 0);
  endtask

  task automatic tSetBeatsClear();
    logic [31:0] v, c;
    parkAll();
    wrReg(3, 32'hFFFF_FFFD);
    c = ctl(1, 0, 3'b000, 8'h20, 8'hFF, 0, 0, 3'b000);
    wrReg(0, c);
    @(negedge clk);
    wrReg(0, c | 32'h0000_0200);
    rdReg(0, v); check("R7 set beats clear", {31'd0, v[9]}, 1);
    check("R9 no irq without enable", {31'd0, irq}, 0);
    parkAll();
  endtask

  task automatic tResets();
    logic [31:0] v;
    parkAll();
    wrReg(1, 32'd5); wrReg(2, 32'd7); wrReg(3, 32'd9);
    wrReg(0, ctl(0, 0, 3'b000, 8'h20, 8'h20, 1, 0, 3'b000));
    rdReg(2, v); check("R8 reset delayed", v, 7);
    @(negedge clk);
    rdReg(2, v); check("R8 event0 cleared", v, 0);
    rdReg(3, v); check("R8 event1 cleared", v, 0);
    rdReg(1, v); check("R8 cycle untouched", v, 5);
    rdReg(0, v); check("R8 reset bits read zero", {30'd0, v[2:1]}, 0);
    wrReg(0, ctl(0, 0, 3'b000, 8'h20, 8'h20, 0, 1, 3'b000));
    @(negedge clk);
    rdReg(1, v); check("R8 cycle cleared", v, 0);
  endtask

  task automatic tPriority();
    logic [31:0] v;
    wrReg(0, ctl(1, 0, 3'b000, 8'hFF, 8'h20, 0, 0, 3'b000));
    wrReg(2, 32'd1000);
    rdReg(2, v); check("R10 write wins", v, 1000);
    @(negedge clk);
    rdReg(2, v); check("R1 counts after write", v, 1001);
    parkAll();
    wrReg(3, 32'h1234_5678);
    rdReg(3, v); check("R1 counter readback", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tCycle();
    tDivider();
    tEvents();
    tStop();
    tOverflow();
    tSetBeatsClear();
    tResets();
    tPriority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule